// File: doc/BRIEF.md
# Supply-Compensated PWM Duty Regulator

This block watches an active-low PWM command line (already synchronised to the clock) and turns each completed command period into an output on time and output period, both counted in clock ticks. When regulation is enabled, the output timing is rescaled from a latched battery-voltage code. The delivered RMS power into a resistive load then tracks the commanded duty and does not depend on the supply. The on time is divided by the voltage ratio and the period is multiplied by it, so the output duty is the input duty times the square of nominal-over-measured voltage. When regulation is disabled, the measured timing is passed straight through.

Glitches on the command line shorter than a programmable filter length are discarded. A command line that produces no falling edge within a timeout window invalidates the result and forces the outputs to zero. The rescaling uses a multiply followed by one shared restoring divider that runs twice per result, once for the on time and once for the period. A result is held until the next one is complete.

Top module: `supply_comp_pwm`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `out_vld` is 0 and `out_on` and `out_per` are 0.
- R2: A command level that differs from the accepted level for fewer than FILT_TICKS consecutive clock samples is discarded. A level held for FILT_TICKS consecutive samples is accepted at the last of those samples. The idle accepted level is high.
- R3: The on time is the tick count from an accepted falling edge to the next accepted rising edge, and the period is the tick count from one accepted falling edge to the next. The first accepted falling edge after reset or after a timeout only starts measurement and produces no result.
- R4: When `reg_en` is 0 at a period-completing falling edge, `out_on` and `out_per` equal the measured on time and period, and `out_vld` is 1, from the clock after that edge.
- R5: When `reg_en` is 1 at a period-completing falling edge, with latched code V, the result is: period = floor(period_in × V / VNOM) and on = floor(on_in × VNOM / V). It appears 2×(TW+VW)+2 clocks after that edge.
- R6: A regulated period above 2^TW−1 is clipped to 2^TW−1. A regulated on time is never larger than the regulated period, so the output duty saturates at 100%.
- R7: `vbat_code` is latched only on a clock where `vbat_vld` is 1, and the latched value is held otherwise. The value after reset is VNOM, and a latched value of 0 is used as 1.
- R8: If TMO_TICKS clocks pass after an accepted falling edge without another one, `out_vld` drops to 0 and both outputs go to 0 on that clock.
- R9: Between results, `out_on`, `out_per` and `out_vld` hold their values.
- R10: `reg_en` counts only at the period-completing falling edge. Changes of `reg_en` elsewhere in the period do not affect that period's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_n | input | 1 | Synchronised active-low PWM command |
| reg_en | input | 1 | 1 = supply-compensated timing, 0 = pass-through |
| vbat_code | input | VW | Battery voltage code, VNOM = nominal voltage |
| vbat_vld | input | 1 | Latch strobe for `vbat_code` |
| out_on | output | TW | Output on time in ticks |
| out_per | output | TW | Output period in ticks |
| out_vld | output | 1 | Output timing is valid |

## Verification
The bench builds the block with TW=9, VW=8, VNOM=128, FILT_TICKS=4 and TMO_TICKS=300. With these values the divider latency is 36 clocks, and a whole result cycle fits in a command period of 80 to 290 ticks. The 9-bit period width makes the clip at 511 reachable with a 290-tick period at full-scale voltage. A low code drives the on time past the period, which exercises the 100% saturation. The short filter lets glitches of exactly FILT_TICKS−1 samples be placed inside both pulse phases. The short timeout lets loss of command, and the re-arm that follows it, be exercised several times within one run.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ON,
        ST_PER
    } scp_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } scp_edge_t;

    function automatic int unsigned bits_for(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/scp_cmd_filter.sv
module scp_cmd_filter
    import scp_pkg::*;
#(
    parameter int unsigned FILT_TICKS = 750
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_n,
    output logic      lvl,
    output scp_edge_t edges
);
    localparam int unsigned RW = bits_for(FILT_TICKS);

    logic [RW-1:0] run_q;
    logic          lvl_q;
    logic          differ;
    logic          flip;

    assign differ = (cmd_n != lvl_q);
    assign flip   = differ && (run_q == RW'(FILT_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            lvl_q <= 1'b1;
        end else if (!differ) begin
            run_q <= '0;
        end else if (flip) begin
            run_q <= '0;
            lvl_q <= cmd_n;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign lvl        = lvl_q;
    assign edges.fall = flip && lvl_q;
    assign edges.rise = flip && !lvl_q;

endmodule

// File: rtl/scp_pulse_meter.sv
module scp_pulse_meter
    import scp_pkg::*;
#(
    parameter int unsigned TW        = 17,
    parameter int unsigned TMO_TICKS = 75000
) (
    input  logic          clk,
    input  logic          rst,
    input  scp_edge_t     edges,
    output logic [TW-1:0] period,
    output logic [TW-1:0] on_len,
    output logic          per_done,
    output logic          tmo
);
    localparam int unsigned CW = bits_for(TMO_TICKS);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] on_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            on_q    <= '0;
            armed_q <= 1'b0;
        end else begin
            if (edges.fall) begin
                cnt_q <= CW'(1);
            end else if (cnt_q != CW'(TMO_TICKS)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (edges.fall) begin
                armed_q <= 1'b1;
            end else if (tmo) begin
                armed_q <= 1'b0;
            end
            if (edges.rise && armed_q) begin
                on_q <= cnt_q;
            end
        end
    end

    assign per_done = edges.fall && armed_q;
    assign tmo      = armed_q && !edges.fall && (cnt_q == CW'(TMO_TICKS));
    assign period   = TW'(cnt_q);
    assign on_len   = TW'(on_q);

endmodule

// File: rtl/scp_seq_div.sv
module scp_seq_div
    import scp_pkg::*;
#(
    parameter int unsigned NW = 27
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [NW-1:0] den,
    output logic [NW-1:0] quo,
    output logic          done
);
    localparam int unsigned SW = bits_for(NW);

    logic [NW-1:0] rem_q;
    logic [NW-1:0] q_q;
    logic [NW-1:0] den_q;
    logic [SW-1:0] step_q;
    logic          busy_q;
    logic          done_q;
    logic [NW:0]   sh;
    logic          fits;

    assign sh   = {rem_q, q_q[NW-1]};
    assign fits = (sh >= {1'b0, den_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            q_q    <= '0;
            den_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                q_q    <= num;
                den_q  <= den;
                step_q <= SW'(NW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (fits) begin
                    rem_q <= NW'(sh - {1'b0, den_q});
                    q_q   <= {q_q[NW-2:0], 1'b1};
                end else begin
                    rem_q <= sh[NW-1:0];
                    q_q   <= {q_q[NW-2:0], 1'b0};
                end
                step_q <= step_q - 1'b1;
                if (step_q == SW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quo  = q_q;
    assign done = done_q;

endmodule

// File: rtl/supply_comp_pwm.sv
module supply_comp_pwm
    import scp_pkg::*;
#(
    parameter int unsigned TW         = 17,
    parameter int unsigned VW         = 10,
    parameter int unsigned VNOM       = 512,
    parameter int unsigned FILT_TICKS = 750,
    parameter int unsigned TMO_TICKS  = 75000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_n,
    input  logic          reg_en,
    input  logic [VW-1:0] vbat_code,
    input  logic          vbat_vld,
    output logic [TW-1:0] out_on,
    output logic [TW-1:0] out_per,
    output logic          out_vld
);
    localparam int unsigned NW = TW + VW;
    localparam logic [NW-1:0] TMAX = {{VW{1'b0}}, {TW{1'b1}}};

    scp_edge_t     edges;
    logic          cmd_lvl;
    logic [TW-1:0] period;
    logic [TW-1:0] on_len;
    logic          per_done;
    logic          tmo_ev;

    logic [VW-1:0] vq;
    logic [VW-1:0] veff;
    logic [VW-1:0] v_hold;
    logic [TW-1:0] per_hold;
    logic [TW-1:0] q_on;
    scp_state_e    st;

    logic          start_on;
    logic          start_per;
    logic          div_start;
    logic [NW-1:0] div_num;
    logic [NW-1:0] div_den;
    logic [NW-1:0] div_quo;
    logic          div_done;
    logic [TW-1:0] quo_sat;

    scp_cmd_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .cmd_n (cmd_n),
        .lvl   (cmd_lvl),
        .edges (edges)
    );

    scp_pulse_meter #(.TW(TW), .TMO_TICKS(TMO_TICKS)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .edges    (edges),
        .period   (period),
        .on_len   (on_len),
        .per_done (per_done),
        .tmo      (tmo_ev)
    );

    scp_seq_div #(.NW(NW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .done  (div_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vq <= VW'(VNOM);
        end else if (vbat_vld) begin
            vq <= vbat_code;
        end
    end

    assign veff = (vq == '0) ? VW'(1) : vq;

    always_comb begin
        start_on  = per_done && reg_en;
        start_per = (st == ST_ON) && div_done;
        div_start = start_on || start_per;
        if (start_on) begin
            div_num = NW'(on_len) * NW'(VNOM);
            div_den = NW'(veff);
        end else begin
            div_num = NW'(per_hold) * NW'(v_hold);
            div_den = NW'(VNOM);
        end
        quo_sat = (div_quo > TMAX) ? {TW{1'b1}} : div_quo[TW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            q_on     <= '0;
            per_hold <= '0;
            v_hold   <= '0;
            out_on   <= '0;
            out_per  <= '0;
            out_vld  <= 1'b0;
        end else begin
            if (st == ST_ON && div_done) begin
                q_on <= quo_sat;
                st   <= ST_PER;
            end else if (st == ST_PER && div_done) begin
                out_per <= quo_sat;
                out_on  <= (q_on > quo_sat) ? quo_sat : q_on;
                out_vld <= 1'b1;
                st      <= ST_IDLE;
            end
            if (per_done) begin
                if (reg_en) begin
                    per_hold <= period;
                    v_hold   <= veff;
                    st       <= ST_ON;
                end else begin
                    out_on  <= on_len;
                    out_per <= period;
                    out_vld <= 1'b1;
                    st      <= ST_IDLE;
                end
            end
            if (tmo_ev) begin
                out_on  <= '0;
                out_per <= '0;
                out_vld <= 1'b0;
                st      <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
    parameter int unsigned TW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_n,
    input logic          cmd_lvl,
    input logic          tmo_ev,
    input logic [TW-1:0] out_on,
    input logic [TW-1:0] out_per,
    input logic          out_vld
);

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_vld && out_on == '0 && out_per == '0));

    // R2
    filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_lvl) |-> (cmd_lvl == $past(cmd_n)));

    // R6
    on_le_per_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_on <= out_per));

    // R8
    tmo_drop_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_ev |=> (!out_vld && out_on == '0 && out_per == '0));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (out_on == '0 && out_per == '0));

endmodule

bind supply_comp_pwm scp_chk #(.TW(TW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .cmd_n   (cmd_n),
    .cmd_lvl (cmd_lvl),
    .tmo_ev  (tmo_ev),
    .out_on  (out_on),
    .out_per (out_per),
    .out_vld (out_vld)
);

// File: tb/supply_comp_pwm_tb_top.sv
`timescale 1ns/1ps
module supply_comp_pwm_tb_top;
    localparam int TW   = 9;
    localparam int VW   = 8;
    localparam int VNOM = 128;
    localparam int FILT = 4;
    localparam int TMO  = 300;
    localparam int LAT  = 2 * (TW + VW) + 2;
    localparam int TMAXV = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_n = 1'b1;
    logic          reg_en = 1'b0;
    logic [VW-1:0] vbat_code = '0;
    logic          vbat_vld = 1'b0;
    logic [TW-1:0] out_on;
    logic [TW-1:0] out_per;
    logic          out_vld;

    int    n_checks = 0;
    int    n_errors = 0;
    string phase = "R1";
    bit    finished = 1'b0;

    always #2.5 clk = ~clk;

    supply_comp_pwm #(
        .TW(TW), .VW(VW), .VNOM(VNOM), .FILT_TICKS(FILT), .TMO_TICKS(TMO)
    ) dut_i (
        .clk(clk), .rst(rst), .cmd_n(cmd_n), .reg_en(reg_en),
        .vbat_code(vbat_code), .vbat_vld(vbat_vld),
        .out_on(out_on), .out_per(out_per), .out_vld(out_vld)
    );

    // behavioural reference model
    int  m_edge = 0, m_run = 0, m_cnt = 0, m_on = 0, m_vq = VNOM;
    bit  m_lvl = 1'b1, m_armed = 1'b0;
    int  e_on = 0, e_per = 0;
    bit  e_vld = 1'b0;
    bit  p_busy = 1'b0;
    int  p_due = 0, p_on = 0, p_per = 0;

    always @(posedge clk) begin
        bit fall, rise, pdone, tmo;
        int per_in;
        longint v, qon, qper;
        m_edge++;
        if (rst) begin
            m_run = 0; m_cnt = 0; m_on = 0; m_vq = VNOM; m_lvl = 1'b1;
            m_armed = 1'b0; e_on = 0; e_per = 0; e_vld = 1'b0; p_busy = 1'b0;
        end else begin
            if (p_busy && m_edge == p_due) begin
                e_on = p_on; e_per = p_per; e_vld = 1'b1; p_busy = 1'b0;
            end
            fall = 1'b0; rise = 1'b0;
            if (cmd_n != m_lvl) begin
                if (m_run == FILT - 1) begin
                    m_run = 0;
                    if (m_lvl) fall = 1'b1; else rise = 1'b1;
                    m_lvl = cmd_n;
                end else begin
                    m_run++;
                end
            end else begin
                m_run = 0;
            end
            pdone  = fall && m_armed;
            tmo    = m_armed && !fall && (m_cnt == TMO);
            per_in = m_cnt;
            if (rise && m_armed) m_on = m_cnt;
            if (fall) m_cnt = 1; else if (m_cnt != TMO) m_cnt++;
            if (fall) m_armed = 1'b1; else if (tmo) m_armed = 1'b0;
            if (pdone) begin
                if (reg_en) begin
                    v    = (m_vq == 0) ? 1 : m_vq;
                    qon  = (longint'(m_on) * VNOM) / v;
                    qper = (longint'(per_in) * v) / VNOM;
                    if (qper > TMAXV) qper = TMAXV;
                    if (qon > qper) qon = qper;
                    p_busy = 1'b1; p_due = m_edge + LAT;
                    p_on = int'(qon); p_per = int'(qper);
                end else begin
                    e_on = m_on; e_per = per_in; e_vld = 1'b1; p_busy = 1'b0;
                end
            end
            if (tmo) begin
                e_on = 0; e_per = 0; e_vld = 1'b0; p_busy = 1'b0;
            end
            if (vbat_vld) m_vq = vbat_code;
        end
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            chk(phase, int'(out_vld), int'(e_vld), "model out_vld");
            chk(phase, int'(out_on),  e_on,  "model out_on");
            chk(phase, int'(out_per), e_per, "model out_per");
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic burst(input int on, input int per, input int n);
        for (int i = 0; i < n; i++) begin
            cmd_n = 1'b0; hold(on);
            cmd_n = 1'b1; hold(per - on);
        end
    endtask

    task automatic burst_glitch(input int n);
        for (int i = 0; i < n; i++) begin
            cmd_n = 1'b0; hold(10);
            cmd_n = 1'b1; hold(FILT - 1);
            cmd_n = 1'b0; hold(30 - 10 - (FILT - 1));
            cmd_n = 1'b1; hold(20);
            cmd_n = 1'b0; hold(FILT - 1);
            cmd_n = 1'b1; hold(70 - 20 - (FILT - 1));
        end
    endtask

    task automatic set_vbat(input int code);
        vbat_code = VW'(code); vbat_vld = 1'b1; hold(1);
        vbat_vld = 1'b0; vbat_code = '0; hold(2);
    endtask

    task automatic expect_out(input string tag, input int vld, input int on, input int per);
        chk(tag, int'(out_vld), vld, "out_vld");
        chk(tag, int'(out_on),  on,  "out_on");
        chk(tag, int'(out_per), per, "out_per");
    endtask

    task automatic report();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        hold(200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog run did not finish actual 0 expected 1");
        report();
    end

    initial begin
        int s_on, s_per, s_vld;
        hold(5);
        expect_out("R1", 0, 0, 0);
        rst = 1'b0;
        hold(1);
        expect_out("R1", 0, 0, 0);

        phase = "R4"; reg_en = 1'b0;
        burst(30, 100, 4);
        expect_out("R4", 1, 30, 100);

        phase = "R7"; reg_en = 1'b1;
        burst(30, 100, 4);
        expect_out("R7", 1, 30, 100);

        phase = "R5"; set_vbat(160);
        burst(30, 100, 4);
        expect_out("R5", 1, 24, 125);
        set_vbat(96);
        burst(40, 100, 4);
        expect_out("R5", 1, 53, 75);

        phase = "R6"; set_vbat(40);
        burst(60, 100, 4);
        expect_out("R6", 1, 31, 31);
        set_vbat(255);
        burst(100, 290, 4);
        expect_out("R6", 1, 50, 511);

        phase = "R7"; set_vbat(0);
        burst(30, 100, 4);
        expect_out("R7", 1, 0, 0);

        phase = "R10"; set_vbat(160); reg_en = 1'b0;
        burst(30, 100, 3);
        cmd_n = 1'b0; hold(30);
        reg_en = 1'b1; cmd_n = 1'b1; hold(40);
        reg_en = 1'b0; hold(30);
        cmd_n = 1'b0; hold(10);
        expect_out("R10", 1, 30, 100);

        phase = "R2";
        burst_glitch(4);
        expect_out("R2", 1, 30, 100);

        phase = "R9";
        s_vld = int'(out_vld); s_on = int'(out_on); s_per = int'(out_per);
        hold(40);
        expect_out("R9", s_vld, s_on, s_per);

        phase = "R8";
        hold(TMO);
        expect_out("R8", 0, 0, 0);

        phase = "R3";
        burst(30, 100, 1);
        hold(50);
        expect_out("R3", 0, 0, 0);
        hold(TMO);
        expect_out("R3", 0, 0, 0);

        report();
    end

endmodule